// File: doc/BRIEF.md
# Context-Tagged Multi-Page-Size Translation Buffer

This block is a fully associative translation cache. It holds recent linear-to-physical translations for pages of 4 KB, 2 MB and 1 GB. Each cached entry records its own page size. The size fixes how many upper linear-address bits take part in the compare, and how many low bits pass straight through to the physical address. Every entry also carries a 12-bit context tag and a global flag, so translations from several address spaces can share the buffer.

A lookup is purely combinational. The 48-bit linear address, the current context and the tagging enable produce a hit flag and a 52-bit physical address in the same cycle. An external page walker installs translations through a fill port. Fills land on the next clock edge, in the lowest-numbered free slot, or in a round-robin slot when all slots are occupied. Three kinds of flush take effect on the next clock edge:

- a full flush,
- a flush of one context, which spares global entries,
- an automatic wipe when context tagging is switched off.

A flush beats a fill issued in the same cycle.

Top module: `ctx_tlb`

## Requirements
- R1: A 4 KB entry (fill_size 0) hits when linear bits 47:12 equal the stored page number. Its physical address is {frame[39:0], linear[11:0]}.
- R2: A 2 MB entry (fill_size 1) hits when linear bits 47:21 match. Its physical address is {frame[39:9], linear[20:0]}. Stored frame bits 8:0 have no effect.
- R3: A 1 GB entry (fill_size 2) hits when linear bits 47:30 match. Its physical address is {frame[39:18], linear[29:0]}. Stored frame bits 17:0 have no effect.
- R4: When no valid entry matches, lk_hit is 0 and lk_paddr is 0.
- R5: With ctx_en=1, a non-global entry hits only when its context tag equals cur_ctx.
- R6: With ctx_en=0, a fill is tagged with context 0 whatever cur_ctx holds. A lookup uses context 0.
- R7: When ctx_en is 1 in one cycle and 0 in the next, every entry is invalidated at that edge, global entries included.
- R8: flush_all invalidates every entry at the next clock edge.
- R9: flush_ctx_req invalidates, at the next edge, every non-global entry whose tag equals flush_ctx_id. Global entries and entries with other tags remain.
- R10: A fill issued in the same cycle as any flush is dropped.
- R11: A fill goes to the lowest-numbered invalid slot. When all 16 slots are valid, the fill replaces the slot at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R12: A global entry hits for any lookup context.
- R13: After reset the buffer is empty, so every lookup misses. A filled entry can be looked up in the cycle after the fill edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_en | input | 1 | Context tagging enable |
| cur_ctx | input | 12 | Current context identifier |
| lk_addr | input | 48 | Lookup linear address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 52 | Translated physical address, 0 on miss |
| fill_req | input | 1 | Install a translation |
| fill_addr | input | 48 | Linear address inside the page being installed |
| fill_frame | input | 40 | Physical page frame (physical bits 51:12) |
| fill_size | input | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_global | input | 1 | Entry ignores context tags |
| flush_all | input | 1 | Invalidate all entries |
| flush_ctx_req | input | 1 | Invalidate non-global entries of one context |
| flush_ctx_id | input | 12 | Context to flush |

## Verification
Each page size is probed with two kinds of address:

- an address that keeps the page number but changes every offset bit, which shows that the right bits pass through and that the low frame bits are ignored;
- an address one bit outside the page, which must miss.

Context behaviour is probed three ways. The same address is looked up under matching, foreign and disabled contexts. A global entry is probed under an unrelated context. Context-specific, full and disable-triggered flushes are each compared for what they keep and what they remove.

Replacement is probed by filling past capacity and then looking up the oldest pages, which shows whether the victim follows free-first order and then round-robin order. A behavioural model of the entry set is compared with the outputs on every cycle.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int LA_W   = 48;
    localparam int PA_W   = 52;
    localparam int CTX_W  = 12;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = LA_W - OFF_W;
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int XTRA_2M = 21 - OFF_W;
    localparam int XTRA_1G = 30 - OFF_W;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        logic              global;
        logic [CTX_W-1:0]  ctx;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        pg_size_e          size;
    } tlb_entry_t;

    // Page-number bits that take part in the compare, per page size.
    function automatic logic [VPN_W-1:0] vpn_keep(pg_size_e s);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (s)
            PG_2M:   return ones << XTRA_2M;
            PG_1G:   return ones << XTRA_1G;
            default: return ones;
        endcase
    endfunction

    // Merge the stored frame with the offset bits of the linear address.
    function automatic logic [PA_W-1:0] build_pa(tlb_entry_t e, logic [LA_W-1:0] la);
        logic [PFN_W-1:0] keep;
        logic [PFN_W-1:0] upper;
        keep  = {{(PFN_W-VPN_W){1'b1}}, vpn_keep(e.size)};
        upper = (e.pfn & keep) | (PFN_W'(la[LA_W-1:OFF_W]) & ~keep);
        return {upper, la[OFF_W-1:0]};
    endfunction

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
    import ctx_tlb_pkg::*;
(
    input  tlb_entry_t              entry_i,
    input  logic [LA_W-1:0]         la_i,
    input  logic [CTX_W-1:0]        ctx_i,
    output logic                    hit_o
);
    logic [VPN_W-1:0] keep;
    logic             page_eq;
    logic             ctx_ok;

    always_comb begin
        keep    = vpn_keep(entry_i.size);
        page_eq = ((entry_i.vpn ^ la_i[LA_W-1:OFF_W]) & keep) == '0;
        ctx_ok  = entry_i.global || (entry_i.ctx == ctx_i);
        hit_o   = entry_i.valid && page_eq && ctx_ok;
    end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_i,
    input  logic             take_i,
    output logic [IDX_W-1:0] victim_o
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim_o = free_any ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (take_i && !free_any) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!(&valid_i)) |-> !valid_i[victim_o]); // R11

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_en,
    input  logic [CTX_W-1:0]  cur_ctx,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_req,
    input  logic [LA_W-1:0]   fill_addr,
    input  logic [PFN_W-1:0]  fill_frame,
    input  logic [1:0]        fill_size,
    input  logic              fill_global,
    input  logic              flush_all,
    input  logic              flush_ctx_req,
    input  logic [CTX_W-1:0]  flush_ctx_id
);
    tlb_entry_t       ent [N];
    tlb_entry_t       new_ent;
    logic [N-1:0]     valid_vec;
    logic [N-1:0]     hit_vec;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic [CTX_W-1:0] eff_ctx;
    logic             ctx_en_q;
    logic             tag_off;
    logic             wipe_all;
    logic             any_flush;
    logic             fill_go;

    assign eff_ctx   = ctx_en ? cur_ctx : '0;
    assign tag_off   = ctx_en_q && !ctx_en;
    assign wipe_all  = tag_off || flush_all;
    assign any_flush = wipe_all || flush_ctx_req;
    assign fill_go   = fill_req && !any_flush;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign valid_vec[g] = ent[g].valid;
        ctx_tlb_match u_match (
            .entry_i (ent[g]),
            .la_i    (lk_addr),
            .ctx_i   (eff_ctx),
            .hit_o   (hit_vec[g])
        );
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        lk_hit   = |hit_vec;
        lk_paddr = lk_hit ? build_pa(ent[hit_idx], lk_addr) : '0;
    end

    ctx_tlb_victim #(.N(N)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_vec),
        .take_i   (fill_go),
        .victim_o (vic_idx)
    );

    always_comb begin
        new_ent.valid  = 1'b1;
        new_ent.global = fill_global;
        new_ent.ctx    = eff_ctx;
        new_ent.vpn    = fill_addr[LA_W-1:OFF_W];
        new_ent.pfn    = fill_frame;
        new_ent.size   = pg_size_e'(fill_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_en_q <= 1'b0;
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else begin
            ctx_en_q <= ctx_en;
            for (int i = 0; i < N; i++) begin
                if (wipe_all) begin
                    ent[i].valid <= 1'b0;
                end else if (flush_ctx_req && ent[i].valid && !ent[i].global
                             && ent[i].ctx == flush_ctx_id) begin
                    ent[i].valid <= 1'b0;
                end else if (fill_go && vic_idx == IDX_W'(i)) begin
                    ent[i] <= new_ent;
                end
            end
        end
    end

    AST_TAG_OFF_WIPES: assert property (@(posedge clk) disable iff (rst)
        (ctx_en_q && !ctx_en) |=> (valid_vec == '0)); // R7

    AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0)); // R8

    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (rst)
        (fill_req && (flush_all || flush_ctx_req))
        |=> ($countones(valid_vec) <= $past($countones(valid_vec)))); // R10

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !flush_all && !flush_ctx_req && !(ctx_en_q && !ctx_en))
        |=> (valid_vec != '0)); // R11

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (valid_vec != '0)); // R4

endmodule

// File: tb/ctx_tlb_test.sv
`timescale 1ns/1ps
module ctx_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctx_en = 1'b0;
    logic [11:0] cur_ctx = '0;
    logic [47:0] lk_addr = '0;
    logic        lk_hit;
    logic [51:0] lk_paddr;
    logic        fill_req = 1'b0;
    logic [47:0] fill_addr = '0;
    logic [39:0] fill_frame = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_global = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_ctx_req = 1'b0;
    logic [11:0] flush_ctx_id = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit ready = 0;
    string cur_tag = "R13";

    always #5 clk = ~clk;

    ctx_tlb uut (
        .clk(clk), .rst(rst), .ctx_en(ctx_en), .cur_ctx(cur_ctx),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_frame(fill_frame),
        .fill_size(fill_size), .fill_global(fill_global),
        .flush_all(flush_all), .flush_ctx_req(flush_ctx_req),
        .flush_ctx_id(flush_ctx_id)
    );

    // Behavioural reference model
    bit          m_v [16];
    bit          m_g [16];
    int          m_c [16];
    logic [47:0] m_a [16];
    logic [39:0] m_f [16];
    int          m_sh [16];
    int          m_ptr = 0;
    bit          m_en_q = 0;

    function automatic int shift_of(logic [1:0] s);
        if (s == 2'd1) return 21;
        if (s == 2'd2) return 30;
        return 12;
    endfunction

    task automatic model_look(input logic [47:0] a, output bit h, output logic [51:0] pa);
        int cx;
        logic [51:0] fr;
        cx = ctx_en ? int'(cur_ctx) : 0;
        h = 0;
        pa = '0;
        for (int i = 0; i < 16; i++) begin
            if (!h && m_v[i] && ((a >> m_sh[i]) == (m_a[i] >> m_sh[i]))
                && (m_g[i] || m_c[i] == cx)) begin
                h = 1;
                fr = {m_f[i], 12'h000};
                pa = ((fr >> m_sh[i]) << m_sh[i]) | (52'(a) & ((52'd1 << m_sh[i]) - 52'd1));
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_v[i] = 0;
            m_ptr = 0;
            m_en_q = 0;
        end else begin
            if ((m_en_q && !ctx_en) || flush_all) begin
                for (int i = 0; i < 16; i++) m_v[i] = 0;
            end else if (flush_ctx_req) begin
                for (int i = 0; i < 16; i++)
                    if (m_v[i] && !m_g[i] && m_c[i] == int'(flush_ctx_id)) m_v[i] = 0;
            end else if (fill_req) begin
                int slot;
                slot = -1;
                for (int i = 15; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_ptr;
                    m_ptr = (m_ptr + 1) % 16;
                end
                m_v[slot] = 1;
                m_g[slot] = fill_global;
                m_c[slot] = ctx_en ? int'(cur_ctx) : 0;
                m_a[slot] = fill_addr;
                m_f[slot] = fill_frame;
                m_sh[slot] = shift_of(fill_size);
            end
            m_en_q = ctx_en;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Compare with the model on every cycle
    always @(negedge clk) begin
        #2;
        if (ready && !rst && !finished) begin
            bit h;
            logic [51:0] pa;
            model_look(lk_addr, h, pa);
            chk({cur_tag, " model hit"}, 64'(lk_hit), 64'(h));
            chk({cur_tag, " model paddr"}, 64'(lk_paddr), 64'(pa));
        end
    end

    task automatic look(input string tag, input logic [47:0] a, input bit eh, input logic [51:0] ep);
        @(negedge clk);
        cur_tag = tag;
        lk_addr = a;
        #1;
        chk({tag, " hit"}, 64'(lk_hit), 64'(eh));
        chk({tag, " paddr"}, 64'(lk_paddr), 64'(ep));
    endtask

    task automatic fill(input logic [47:0] a, input logic [39:0] f, input logic [1:0] s, input bit g);
        @(negedge clk);
        fill_req = 1; fill_addr = a; fill_frame = f; fill_size = s; fill_global = g;
        @(negedge clk);
        fill_req = 0; fill_global = 0;
    endtask

    task automatic setctx(input bit en, input logic [11:0] c);
        @(negedge clk);
        ctx_en = en;
        cur_ctx = c;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        ready = 1;
        look("R13", 48'h0000_1234_5ABC, 0, 52'h0);

        setctx(1, 12'd3);
        // R1 4 KB page
        fill(48'h0000_1234_5000, 40'hAB_CDEF_0123, 2'd0, 0);
        look("R1", 48'h0000_1234_5ABC, 1, 52'hABCDEF0123ABC);
        look("R4", 48'h0000_1234_4ABC, 0, 52'h0);
        // R2 2 MB page, low frame bits set
        fill(48'h0000_4060_0000, 40'h11_2233_41FF, 2'd1, 0);
        look("R2", 48'h0000_407F_FFFF, 1, 52'h11223341FFFFF);
        look("R4", 48'h0000_4080_0000, 0, 52'h0);
        // R3 1 GB page
        fill(48'h0012_C000_0000, 40'h98_7654_3FFF, 2'd2, 0);
        look("R3", 48'h0012_F123_4567, 1, 52'h9876571234567);
        look("R4", 48'h0013_0000_0000, 0, 52'h0);

        // R5 foreign context
        setctx(1, 12'd4);
        look("R5", 48'h0000_1234_5ABC, 0, 52'h0);
        // R12 global entry
        fill(48'h7000_0000_0000, 40'h1, 2'd0, 1);
        setctx(1, 12'd9);
        look("R12", 48'h7000_0000_0010, 1, 52'h0000000001010);
        setctx(1, 12'd5);
        fill(48'h5000_0000_0000, 40'h5, 2'd0, 0);

        // R9 flush one context
        @(negedge clk);
        cur_tag = "R9";
        flush_ctx_req = 1; flush_ctx_id = 12'd3;
        @(negedge clk);
        flush_ctx_req = 0;
        look("R9", 48'h5000_0000_0004, 1, 52'h0000000005004);
        setctx(1, 12'd3);
        look("R9", 48'h0000_1234_5ABC, 0, 52'h0);
        look("R9", 48'h0012_F123_4567, 0, 52'h0);
        look("R9", 48'h7000_0000_0010, 1, 52'h0000000001010);

        // R10 and R8: flush_all with a fill in the same cycle
        @(negedge clk);
        cur_tag = "R10";
        flush_all = 1; fill_req = 1; fill_addr = 48'h6000_0000_0000;
        fill_frame = 40'h6; fill_size = 2'd0;
        @(negedge clk);
        flush_all = 0; fill_req = 0;
        look("R10", 48'h6000_0000_0000, 0, 52'h0);
        look("R8", 48'h7000_0000_0010, 0, 52'h0);

        // R11 replacement
        for (int i = 0; i < 18; i++)
            fill(48'h0000_0100_0000 | (48'(i) << 12), 40'(i + 'h100), 2'd0, 0);
        look("R11", 48'h0000_0100_0000, 0, 52'h0);
        look("R11", 48'h0000_0100_1000, 0, 52'h0);
        look("R11", 48'h0000_0100_2000, 1, 52'h0000000102000);
        look("R11", 48'h0000_0101_0008, 1, 52'h0000000110008);
        look("R11", 48'h0000_0101_1008, 1, 52'h0000000111008);

        // R7 disabling tagging wipes everything, global included
        fill(48'h7000_0000_0000, 40'h1, 2'd0, 1);
        look("R12", 48'h7000_0000_0010, 1, 52'h0000000001010);
        setctx(0, 12'd3);
        look("R7", 48'h7000_0000_0010, 0, 52'h0);
        look("R7", 48'h0000_0100_2000, 0, 52'h0);

        // R6 disabled tagging uses context 0
        setctx(0, 12'd7);
        fill(48'h2000_0000_0000, 40'h22, 2'd0, 0);
        look("R6", 48'h2000_0000_0123, 1, 52'h0000000022123);
        setctx(1, 12'd7);
        look("R6", 48'h2000_0000_0123, 0, 52'h0);
        setctx(1, 12'd0);
        look("R6", 48'h2000_0000_0123, 1, 52'h0000000022123);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule